// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is a purely combinational integer data-processing unit for a 64-bit datapath. It takes two operands, a 4-bit operation code, a set-flags request, a width select and the current carry flag. It returns the result, a fresh four-bit condition word and a write enable for the condition register. The width select chooses between full 64-bit arithmetic and 32-bit arithmetic. In 32-bit mode, the arithmetic, the carry and overflow positions, the sign bit and the zero test all work on the low word.

There are two families of operations. The arithmetic family is add, subtract, and the carry-chained forms of both. The bitwise family is AND, AND-with-complement, OR, OR-with-complement, XOR and XOR-with-complement. Subtraction runs as an add of the complemented second operand, so a set carry means no borrow occurred. The AND forms can update the flags, with carry and overflow forced clear. The OR and XOR forms never update the flags. Shifting or extending the operands happens before this block, and the flag register itself sits after it.

Top module: `flag_alu`

## Requirements
- R1: Opcode encoding: 0 ADD, 1 SUB, 2 ADC, 3 SBC, 4 AND, 5 BIC (a AND NOT b), 6 ORR, 7 ORN (a OR NOT b), 8 EOR, 9 EON (a XOR NOT b). ADD returns a+b and SUB returns a-b, both modulo 2^width.
- R2: ADC returns a+b+cin_flag. SBC returns a-b-(1-cin_flag), which is the same as a+NOT b+cin_flag.
- R3: The six bitwise opcodes return their bitwise function of the two operands at the active width.
- R4: When `wide`=0, the operation uses only the low 32 bits of each operand, and result[63:32] is zero.
- R5: The condition word is ordered {N,Z,C,V} from bit 3 down to bit 0. N equals result bit 63 when `wide`=1 and result bit 31 when `wide`=0.
- R6: Z is 1 exactly when the result at the active width is all zeros.
- R7: For arithmetic ops, C is the carry out of the active width. For SUB and SBC this means C=1 when no borrow occurred.
- R8: For arithmetic ops, V is 1 when the two addends (the second one complemented for SUB and SBC) have the same sign and the result sign differs from it.
- R9: For flag-setting AND and BIC, C and V are 0.
- R10: `flags_we` equals `set_flags` for opcodes 0 to 5. It is 0 for ORR, ORN, EOR and EON.
- R11: Opcodes 10 to 15 give a zero result with `flags_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| opcode | input | 4 | Operation select (encoding in R1) |
| set_flags | input | 1 | Request the flag-setting variant |
| wide | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| cin_flag | input | 1 | Current carry flag |
| result | output | 64 | Operation result |
| nzcv | output | 4 | New condition word {N,Z,C,V} |
| flags_we | output | 1 | Condition register write enable |

## Verification
Several rules are checked on every evaluation by assertions in the design:
- the high word is zero in 32-bit mode;
- N follows the sign bit of the active width;
- a set Z flag implies a zero result;
- the AND forms leave carry and overflow clear;
- the OR and XOR forms and the unused opcodes never enable a flag write.

Other behaviour can only be shown by the bench scenarios, which compare against an independent reference model:
- the arithmetic values themselves;
- the correctness of carry and overflow at both widths, including borrow on subtract and the chained carry in ADC and SBC;
- Z being set when the high word holds data in 32-bit mode.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'd0;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ADC = 4'd2;
  localparam logic [OPC_W-1:0] OPC_SBC = 4'd3;
  localparam logic [OPC_W-1:0] OPC_AND = 4'd4;
  localparam logic [OPC_W-1:0] OPC_BIC = 4'd5;
  localparam logic [OPC_W-1:0] OPC_ORR = 4'd6;
  localparam logic [OPC_W-1:0] OPC_ORN = 4'd7;
  localparam logic [OPC_W-1:0] OPC_EOR = 4'd8;
  localparam logic [OPC_W-1:0] OPC_EON = 4'd9;

  typedef enum logic [1:0] {CLS_NONE, CLS_ARITH, CLS_LOGIC} op_class_e;
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_sel_e;
  typedef enum logic [1:0] {LOP_AND, LOP_OR, LOP_XOR} logic_op_e;

  typedef struct packed {
    op_class_e cls;
    logic      inv_b;
    cin_sel_e  cin;
    logic_op_e lop;
    logic      flag_ok;
  } dec_t;
endpackage

// File: rtl/flag_alu_decode.sv
module flag_alu_decode
  import flag_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);
  always_comb begin
    dec = '{cls: CLS_NONE, inv_b: 1'b0, cin: CIN_ZERO, lop: LOP_AND, flag_ok: 1'b0};
    case (opcode)
      OPC_ADD: dec = '{cls: CLS_ARITH, inv_b: 1'b0, cin: CIN_ZERO, lop: LOP_AND, flag_ok: 1'b1};
      OPC_SUB: dec = '{cls: CLS_ARITH, inv_b: 1'b1, cin: CIN_ONE,  lop: LOP_AND, flag_ok: 1'b1};
      OPC_ADC: dec = '{cls: CLS_ARITH, inv_b: 1'b0, cin: CIN_FLAG, lop: LOP_AND, flag_ok: 1'b1};
      OPC_SBC: dec = '{cls: CLS_ARITH, inv_b: 1'b1, cin: CIN_FLAG, lop: LOP_AND, flag_ok: 1'b1};
      OPC_AND: dec = '{cls: CLS_LOGIC, inv_b: 1'b0, cin: CIN_ZERO, lop: LOP_AND, flag_ok: 1'b1};
      OPC_BIC: dec = '{cls: CLS_LOGIC, inv_b: 1'b1, cin: CIN_ZERO, lop: LOP_AND, flag_ok: 1'b1};
      OPC_ORR: dec = '{cls: CLS_LOGIC, inv_b: 1'b0, cin: CIN_ZERO, lop: LOP_OR,  flag_ok: 1'b0};
      OPC_ORN: dec = '{cls: CLS_LOGIC, inv_b: 1'b1, cin: CIN_ZERO, lop: LOP_OR,  flag_ok: 1'b0};
      OPC_EOR: dec = '{cls: CLS_LOGIC, inv_b: 1'b0, cin: CIN_ZERO, lop: LOP_XOR, flag_ok: 1'b0};
      OPC_EON: dec = '{cls: CLS_LOGIC, inv_b: 1'b1, cin: CIN_ZERO, lop: LOP_XOR, flag_ok: 1'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         wide,
  output logic [W-1:0] sum,
  output logic         c,
  output logic         v
);
  localparam int HW = W - NW;

  logic [W:0]  full_sum;
  logic [NW:0] part_sum;

  always_comb begin
    full_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    part_sum = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
    if (wide) begin
      sum = full_sum[W-1:0];
      c   = full_sum[W];
      v   = (a[W-1] == b[W-1]) && (full_sum[W-1] != a[W-1]);
    end else begin
      sum = {{HW{1'b0}}, part_sum[NW-1:0]};
      c   = part_sum[NW];
      v   = (a[NW-1] == b[NW-1]) && (part_sum[NW-1] != a[NW-1]);
    end
  end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_op_e    lop,
  input  logic         wide,
  output logic [W-1:0] y
);
  localparam int HW = W - NW;
  logic [W-1:0] raw;

  always_comb begin
    case (lop)
      LOP_OR:  raw = a | b;
      LOP_XOR: raw = a ^ b;
      default: raw = a & b;
    endcase
    y = wide ? raw : {{HW{1'b0}}, raw[NW-1:0]};
  end
endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
  import flag_alu_pkg::*;
#(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic [W-1:0] res,
  input  logic         wide,
  input  op_class_e    cls,
  input  logic         c_arith,
  input  logic         v_arith,
  output logic [3:0]   nzcv
);
  logic n_bit, z_bit, arith;

  always_comb begin
    arith = (cls == CLS_ARITH);
    n_bit = wide ? res[W-1] : res[NW-1];
    z_bit = wide ? (res == '0) : (res[NW-1:0] == '0);
    nzcv  = {n_bit, z_bit, arith & c_arith, arith & v_arith};
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [OPC_W-1:0] opcode,
  input  logic             set_flags,
  input  logic             wide,
  input  logic             cin_flag,
  output logic [W-1:0]     result,
  output logic [3:0]       nzcv,
  output logic             flags_we
);
  dec_t         dec;
  logic [W-1:0] b_eff, add_sum, log_y;
  logic         add_cin, add_c, add_v;

  flag_alu_decode u_dec (.opcode(opcode), .dec(dec));

  always_comb begin
    b_eff = dec.inv_b ? ~op_b : op_b;
    case (dec.cin)
      CIN_ONE:  add_cin = 1'b1;
      CIN_FLAG: add_cin = cin_flag;
      default:  add_cin = 1'b0;
    endcase
  end

  flag_alu_adder #(.W(W), .NW(NW)) u_add (
    .a(op_a), .b(b_eff), .cin(add_cin), .wide(wide),
    .sum(add_sum), .c(add_c), .v(add_v)
  );

  flag_alu_logic #(.W(W), .NW(NW)) u_log (
    .a(op_a), .b(b_eff), .lop(dec.lop), .wide(wide), .y(log_y)
  );

  always_comb begin
    case (dec.cls)
      CLS_ARITH: result = add_sum;
      CLS_LOGIC: result = log_y;
      default:   result = '0;
    endcase
    flags_we = set_flags & dec.flag_ok;
  end

  flag_alu_flags #(.W(W), .NW(NW)) u_flg (
    .res(result), .wide(wide), .cls(dec.cls),
    .c_arith(add_c), .v_arith(add_v), .nzcv(nzcv)
  );

  always_comb begin
    a_r4_upper_zero: assert (wide || result[W-1:NW] == '0)
      else $error("R4: upper word not zero in narrow mode");
    a_r5_sign_flag: assert (nzcv[3] == (wide ? result[W-1] : result[NW-1]))
      else $error("R5: N does not follow result sign");
    a_r6_zero_flag: assert (!nzcv[2] || result == '0)
      else $error("R6: Z set with nonzero result");
    a_r9_logic_cv: assert (!(flags_we && (opcode == OPC_AND || opcode == OPC_BIC)) || nzcv[1:0] == 2'b00)
      else $error("R9: logic op produced C or V");
    a_r10_no_flag_or_xor: assert (!(opcode inside {OPC_ORR, OPC_ORN, OPC_EOR, OPC_EON}) || !flags_we)
      else $error("R10: flag write on non-flag op");
    a_r11_unknown_op: assert (opcode <= OPC_EON || (result == '0 && !flags_we))
      else $error("R11: unknown opcode not quiet");
  end
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0, wide = 1'b1, cin_flag = 1'b0;
  logic [63:0] result;
  logic [3:0]  nzcv;
  logic        flags_we;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [68:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  flag_alu uut (
    .op_a(op_a), .op_b(op_b), .opcode(opcode), .set_flags(set_flags),
    .wide(wide), .cin_flag(cin_flag), .result(result), .nzcv(nzcv), .flags_we(flags_we)
  );

  function automatic logic [68:0] model(input logic [63:0] a, input logic [63:0] b,
      input logic [3:0] op, input logic sf, input logic w, input logic ci);
    logic [63:0] mask, aa, bb, r;
    logic [65:0] ud, sa, sb, ss, rs;
    logic cf, vf, we, arith;
    mask = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    aa = a & mask; bb = b & mask;
    sa = w ? {{2{a[63]}}, a} : {{34{a[31]}}, a[31:0]};
    sb = w ? {{2{b[63]}}, b} : {{34{b[31]}}, b[31:0]};
    cf = 1'b0; vf = 1'b0; r = '0; arith = 1'b0; ss = '0; ud = '0;
    case (op)
      4'd0, 4'd2: begin
        arith = 1'b1;
        ud = {2'b0, aa} + {2'b0, bb} + ((op == 4'd2) ? {65'd0, ci} : 66'd0);
        ss = sa + sb + ((op == 4'd2) ? {65'd0, ci} : 66'd0);
        r = ud[63:0] & mask;
        cf = w ? ud[64] : ud[32];
      end
      4'd1, 4'd3: begin
        arith = 1'b1;
        ud = {2'b0, aa} - {2'b0, bb} - ((op == 4'd3) ? {65'd0, ~ci} : 66'd0);
        ss = sa - sb - ((op == 4'd3) ? {65'd0, ~ci} : 66'd0);
        r = ud[63:0] & mask;
        cf = ~ud[65];
      end
      4'd4: r = aa & bb;
      4'd5: r = aa & ~bb & mask;
      4'd6: r = aa | bb;
      4'd7: r = (aa | ~bb) & mask;
      4'd8: r = aa ^ bb;
      4'd9: r = (aa ^ ~bb) & mask;
      default: r = '0;
    endcase
    if (arith) begin
      rs = w ? {{2{r[63]}}, r} : {{34{r[31]}}, r[31:0]};
      vf = (ss != rs);
    end
    we = sf && (op <= 4'd5);
    return {we, (w ? r[63] : r[31]), (r == 64'd0), cf, vf, r};
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [3:0] op,
      input logic sf, input logic w, input logic ci, input string tag);
    @(posedge clk);
    op_a = a; op_b = b; opcode = op; set_flags = sf; wide = w; cin_flag = ci;
    exp_q.push_back(model(a, b, op, sf, w, ci));
    tag_q.push_back(tag);
  endtask

  // Monitor: compare one item at each falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [68:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (result !== e[63:0]) begin
        fails++;
        $display("FAIL %s result: actual %h expected %h", t, result, e[63:0]);
      end
      checks++;
      if (flags_we !== e[68]) begin
        fails++;
        $display("FAIL %s flags_we: actual %b expected %b", t, flags_we, e[68]);
      end
      if (e[68]) begin
        checks++;
        if (nzcv !== e[67:64]) begin
          fails++;
          $display("FAIL %s nzcv: actual %b expected %b", t, nzcv, e[67:64]);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] x, y;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    drive(64'd0, 64'd0, 4'd0, 1'b0, 1'b1, 1'b0, "R1 idle");
    drive(64'd5, 64'd7, 4'd0, 1'b1, 1'b1, 1'b0, "R1 add");
    drive(64'd9, 64'd4, 4'd1, 1'b1, 1'b1, 1'b0, "R1 sub");
    drive(64'd5, 64'd7, 4'd0, 1'b0, 1'b1, 1'b0, "R10 add no flags");
    drive(64'd10, 64'd3, 4'd2, 1'b1, 1'b1, 1'b1, "R2 adc c1");
    drive(64'd10, 64'd3, 4'd3, 1'b1, 1'b1, 1'b0, "R2 sbc c0");
    drive(64'd10, 64'd3, 4'd3, 1'b1, 1'b1, 1'b1, "R2 sbc c1");
    drive(64'hF0F0, 64'hFF00, 4'd4, 1'b0, 1'b1, 1'b0, "R3 and");
    drive(64'hF0F0, 64'hFF00, 4'd5, 1'b0, 1'b1, 1'b0, "R3 bic");
    drive(64'hF0F0, 64'hFF00, 4'd6, 1'b1, 1'b1, 1'b0, "R3 R10 orr");
    drive(64'hF0F0, 64'hFF00, 4'd7, 1'b1, 1'b1, 1'b0, "R3 R10 orn");
    drive(64'hF0F0, 64'hFF00, 4'd8, 1'b1, 1'b1, 1'b0, "R3 R10 eor");
    drive(64'hF0F0, 64'hFF00, 4'd9, 1'b1, 1'b0, 1'b0, "R3 R10 eon narrow");
    drive(64'hDEAD_BEEF_0000_0001, 64'hFFFF_0000_0000_0002, 4'd0, 1'b1, 1'b0, 1'b0, "R4 narrow add");
    drive(64'h8000_0000_0000_0000, 64'd0, 4'd0, 1'b1, 1'b1, 1'b0, "R5 n wide");
    drive(64'h0000_0001_8000_0000, 64'd0, 4'd0, 1'b1, 1'b0, 1'b0, "R5 n narrow");
    drive(64'd77, 64'd77, 4'd1, 1'b1, 1'b1, 1'b0, "R6 R7 sub equal");
    drive(64'hFFFF_FFFF_0000_0000, 64'd0, 4'd0, 1'b1, 1'b0, 1'b0, "R6 z narrow");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'd0, 1'b1, 1'b1, 1'b0, "R7 carry wide");
    drive(64'h0000_0000_FFFF_FFFF, 64'd1, 4'd0, 1'b1, 1'b0, 1'b0, "R7 carry narrow");
    drive(64'd1, 64'd2, 4'd1, 1'b1, 1'b1, 1'b0, "R7 borrow");
    drive(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 4'd0, 1'b1, 1'b1, 1'b0, "R8 add ovf wide");
    drive(64'h1234_5678_7FFF_FFFF, 64'd1, 4'd0, 1'b1, 1'b0, 1'b0, "R8 add ovf narrow");
    drive(64'h8000_0000_0000_0000, 64'd1, 4'd1, 1'b1, 1'b1, 1'b0, "R8 sub ovf");
    drive(64'h8000_0000_0000_0000, 64'hFFFF_0000_0000_0000, 4'd4, 1'b1, 1'b1, 1'b0, "R9 and flags");
    drive(64'hFF, 64'hFF, 4'd5, 1'b1, 1'b1, 1'b0, "R9 bic zero");
    for (int k = 10; k < 16; k++)
      drive(64'hABCD, 64'h1234, 4'(k), 1'b1, 1'b1, 1'b1, "R11 unknown");
    x = 64'h9E37_79B9_7F4A_7C15; y = 64'hC2B2_AE3D_27D4_EB4F;
    for (int i = 0; i < 400; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      y = y + x;
      drive(x, y, 4'(i % 10), x[0], x[1], y[2], "R1 R2 R3 R7 R8 sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule